// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit turns a logical address into a linear address. A logical address is a 16-bit segment selector plus a 32-bit offset. The selector names a descriptor slot in one of two in-memory tables, a global one or a local one. Software programs the base address and the byte limit of each table on four inputs. For each accepted request, the unit checks the selector against the chosen table. If the check passes, it fetches the 8-byte descriptor as two 32-bit words over a valid/ready read port. It then gathers the segment base from the three places the base is spread across the descriptor, and adds the offset.

Each request produces one result: a linear address and a fault flag. The result is held in registers and marked by a single-cycle valid pulse. The unit takes one request at a time. While a translation is in flight it reports busy and refuses new work.

Top module: `segx_top`

## Requirements
- R1: Selector bits 15:3 are the descriptor index and bit 2 is the table select. Bits 1:0 have no effect on the result, the fault flag or the memory reads.
- R2: Table select 0 uses `gblBase`/`gblLimit`. Table select 1 uses `ldtBase`/`ldtLimit`.
- R3: The first memory read is at table base + index*8 (descriptor bits 31:0). The second read is at that address + 4 (descriptor bits 63:32).
- R4: The segment base is assembled as base[15:0] = descriptor[31:16], base[23:16] = descriptor[39:32] and base[31:24] = descriptor[63:56].
- R5: `resLinAddr` = segment base + offset, modulo 2^32.
- R6: If index*8+7 is greater than the selected limit, the result is a fault, and no memory read is issued.
- R7: Index 0 with table select 0 is a fault with no memory read. Index 0 in the local table translates normally.
- R8: `resValid` is high for exactly one cycle per request. It is due 1 cycle after acceptance for a fault, and 5 cycles after acceptance for a translation when memory answers with zero wait. A fault returns address 0.
- R9: `reqReady` is high only while idle. `busy` is high from the cycle after acceptance through the result cycle. A request held during busy is not taken.
- R10: After reset the unit is idle: `reqReady`=1, `busy`=0, `memReqValid`=0, `resValid`=0.
- R11: A descriptor with base 0, such as 0x00cf9a000000ffff, yields `resLinAddr` equal to the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Unit idle, request taken this cycle |
| reqSel | input | 16 | Segment selector |
| reqOff | input | 32 | Offset within segment |
| gblBase | input | 32 | Global table base address |
| gblLimit | input | LIM_W | Global table byte limit (inclusive) |
| ldtBase | input | 32 | Local table base address |
| ldtLimit | input | LIM_W | Local table byte limit (inclusive) |
| memReqValid | output | 1 | Memory read request |
| memReqReady | input | 1 | Memory accepts request |
| memReqAddr | output | 32 | Memory read byte address |
| memRspValid | input | 1 | Read data returned |
| memRspData | input | 32 | Read data word |
| resValid | output | 1 | Result valid pulse |
| resLinAddr | output | 32 | Linear address |
| resFault | output | 1 | Translation fault |
| busy | output | 1 | Translation in flight |

## Verification
The bench raises a request and counts falling edges until `resValid` goes high. A fault must arrive on the first edge after acceptance. A full walk must arrive on the fifth edge, because the memory model answers each read one cycle after its handshake. On the edge where the result arrives, the bench samples the address, the fault flag, the count of memory reads and both read addresses. On the next edge it confirms that the pulse has ended and that `reqReady` has returned.

// File: rtl/segx_pkg.sv
package segx_pkg;
  localparam int SEL_W   = 16;
  localparam int IDX_W   = 13;
  localparam int ADDR_W  = 32;
  localparam int WORD_W  = 32;
  localparam int DESC_SH = 3;   // 8-byte descriptors
  localparam int HI_OFF  = 4;   // byte offset of upper word

  typedef enum logic [2:0] {
    ST_IDLE, ST_RDLO, ST_WTLO, ST_RDHI, ST_WTHI, ST_DONE
  } segxState_t;

  typedef struct packed {
    logic take;       // latch request and table registers
    logic hiHalf;     // address the upper descriptor word
    logic capLo;      // capture lower word
    logic capHi;      // capture upper word, form result
    logic flagFault;  // form a fault result
  } segxStrobe_t;
endpackage

// File: rtl/segx_dp.sv
module segx_dp
  import segx_pkg::*;
#(
  parameter int LIM_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  segxStrobe_t         strobe,
  input  logic [SEL_W-1:0]    reqSel,
  input  logic [ADDR_W-1:0]   reqOff,
  input  logic [ADDR_W-1:0]   gblBase,
  input  logic [LIM_W-1:0]    gblLimit,
  input  logic [ADDR_W-1:0]   ldtBase,
  input  logic [LIM_W-1:0]    ldtLimit,
  input  logic [WORD_W-1:0]   memRspData,
  output logic                chkFault,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [ADDR_W-1:0]   linAddr,
  output logic                fault
);
  localparam int CMP_W = (LIM_W > IDX_W + DESC_SH) ? LIM_W : IDX_W + DESC_SH;

  logic                useLocal;
  logic [IDX_W-1:0]    idx;
  logic [CMP_W-1:0]    lastByte;
  logic [CMP_W-1:0]    limSel;

  assign useLocal = reqSel[2];
  assign idx      = reqSel[SEL_W-1:3];
  assign lastByte = CMP_W'({idx, {DESC_SH{1'b1}}});
  assign limSel   = CMP_W'(useLocal ? ldtLimit : gblLimit);
  assign chkFault = (lastByte > limSel) || (!useLocal && idx == '0);

  logic [ADDR_W-1:0] tblBaseQ, offQ, linQ;
  logic [IDX_W-1:0]  idxQ;
  logic [WORD_W-1:0] loWordQ;
  logic              faultQ;
  logic [ADDR_W-1:0] descAddr;
  logic [ADDR_W-1:0] segBase;

  assign descAddr = tblBaseQ + (ADDR_W'(idxQ) << DESC_SH);
  assign memAddr  = descAddr + (strobe.hiHalf ? ADDR_W'(HI_OFF) : '0);
  assign segBase  = {memRspData[31:24], memRspData[7:0], loWordQ[31:16]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tblBaseQ <= '0;
      offQ     <= '0;
      idxQ     <= '0;
      loWordQ  <= '0;
      linQ     <= '0;
      faultQ   <= 1'b0;
    end else begin
      if (strobe.take) begin
        tblBaseQ <= useLocal ? ldtBase : gblBase;
        idxQ     <= idx;
        offQ     <= reqOff;
      end
      if (strobe.capLo) loWordQ <= memRspData;
      if (strobe.capHi) begin
        linQ   <= segBase + offQ;
        faultQ <= 1'b0;
      end else if (strobe.flagFault) begin
        linQ   <= '0;
        faultQ <= 1'b1;
      end
    end
  end

  assign linAddr = linQ;
  assign fault   = faultQ;
endmodule

// File: rtl/segx_ctrl.sv
module segx_ctrl
  import segx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        chkFault,
  input  logic        memReqReady,
  input  logic        memRspValid,
  output segxStrobe_t strobe,
  output logic        reqReady,
  output logic        memReqValid,
  output logic        resValid,
  output logic        busy
);
  segxState_t state, stateNx;

  always_comb begin
    stateNx = state;
    strobe  = '0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        strobe.take = 1'b1;
        if (chkFault) begin
          strobe.flagFault = 1'b1;
          stateNx = ST_DONE;
        end else begin
          stateNx = ST_RDLO;
        end
      end
      ST_RDLO: if (memReqReady) stateNx = ST_WTLO;
      ST_WTLO: if (memRspValid) begin
        strobe.capLo = 1'b1;
        stateNx = ST_RDHI;
      end
      ST_RDHI: begin
        strobe.hiHalf = 1'b1;
        if (memReqReady) stateNx = ST_WTHI;
      end
      ST_WTHI: if (memRspValid) begin
        strobe.capHi = 1'b1;
        stateNx = ST_DONE;
      end
      ST_DONE: stateNx = ST_IDLE;
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNx;
  end

  assign reqReady    = (state == ST_IDLE);
  assign busy        = (state != ST_IDLE);
  assign memReqValid = (state == ST_RDLO) || (state == ST_RDHI);
  assign resValid    = (state == ST_DONE);
endmodule

// File: rtl/segx_top.sv
module segx_top
  import segx_pkg::*;
#(
  parameter int LIM_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [15:0]        reqSel,
  input  logic [31:0]        reqOff,
  input  logic [31:0]        gblBase,
  input  logic [LIM_W-1:0]   gblLimit,
  input  logic [31:0]        ldtBase,
  input  logic [LIM_W-1:0]   ldtLimit,
  output logic               memReqValid,
  input  logic               memReqReady,
  output logic [31:0]        memReqAddr,
  input  logic               memRspValid,
  input  logic [31:0]        memRspData,
  output logic               resValid,
  output logic [31:0]        resLinAddr,
  output logic               resFault,
  output logic               busy
);
  segxStrobe_t strobe;
  logic        chkFault;

  segx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .chkFault(chkFault),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .strobe(strobe),
    .reqReady(reqReady), .memReqValid(memReqValid), .resValid(resValid),
    .busy(busy)
  );

  segx_dp #(.LIM_W(LIM_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqSel(reqSel), .reqOff(reqOff),
    .gblBase(gblBase), .gblLimit(gblLimit), .ldtBase(ldtBase),
    .ldtLimit(ldtLimit), .memRspData(memRspData), .chkFault(chkFault),
    .memAddr(memReqAddr), .linAddr(resLinAddr), .fault(resFault)
  );
endmodule

// File: rtl/segx_chk.sv
module segx_chk #(
  parameter int LIM_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic [15:0]      reqSel,
  input logic [LIM_W-1:0] gblLimit,
  input logic [LIM_W-1:0] ldtLimit,
  input logic             memReqValid,
  input logic             memReqReady,
  input logic [31:0]      memReqAddr,
  input logic             resValid,
  input logic             resFault,
  input logic             busy
);
  logic [31:0] endByte, limPick;
  assign endByte = 32'({reqSel[15:3], 3'b111});
  assign limPick = 32'(reqSel[2] ? ldtLimit : gblLimit);

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  p_busy_after_take_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> busy);

  p_no_read_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReqValid);

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

  p_limit_fault_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && endByte > limPick) |=> (resValid && resFault && !memReqValid));

  p_null_fault_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqSel[2] && reqSel[15:3] == 13'd0) |=> (resValid && resFault));
endmodule

bind segx_top segx_chk #(.LIM_W(LIM_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqSel(reqSel), .gblLimit(gblLimit), .ldtLimit(ldtLimit),
  .memReqValid(memReqValid), .memReqReady(memReqReady),
  .memReqAddr(memReqAddr), .resValid(resValid), .resFault(resFault),
  .busy(busy)
);

// File: tb/sim_segx_top.sv
`timescale 1ns/1ps
module sim_segx_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [15:0] reqSel = '0;
  logic [31:0] reqOff = '0;
  logic [31:0] gblBase = 32'h100;
  logic [15:0] gblLimit = 16'h00FF;
  logic [31:0] ldtBase = 32'h200;
  logic [15:0] ldtLimit = 16'h003F;
  logic        memReqValid;
  logic        memReqReady = 1'b1;
  logic [31:0] memReqAddr;
  logic        memRspValid;
  logic [31:0] memRspData;
  logic        resValid;
  logic [31:0] resLinAddr;
  logic        resFault;
  logic        busy;

  always #4 clk = ~clk;

  segx_top u0 (.*);

  logic [31:0] mem [0:255];
  logic        clrRd = 1'b0;
  int          rdCount;
  logic [31:0] rdAddr0, rdAddr1;

  always @(posedge clk) begin
    if (!rstN) begin
      memRspValid <= 1'b0;
      memRspData  <= '0;
    end else begin
      memRspValid <= memReqValid && memReqReady;
      memRspData  <= mem[memReqAddr[9:2]];
    end
    if (clrRd) rdCount <= 0;
    else if (memReqValid && memReqReady) begin
      if (rdCount == 0) rdAddr0 <= memReqAddr;
      else rdAddr1 <= memReqAddr;
      rdCount <= rdCount + 1;
    end
  end

  int nChecks = 0;
  int nErrors = 0;
  bit doneFlag = 1'b0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic putDesc(int byteAddr, logic [31:0] segBase);
    mem[byteAddr >> 2]       = {segBase[15:0], 16'hffff};
    mem[(byteAddr >> 2) + 1] = {segBase[31:24], 16'hcf92, segBase[23:16]};
  endtask

  task automatic xlate(string req, logic [15:0] sel, logic [31:0] off,
                       logic [31:0] expLin, bit expFault, logic [31:0] firstAddr,
                       bit holdJunk);
    int lat;
    int expLat;
    expLat = expFault ? 1 : 5;
    @(negedge clk);
    chk(reqReady, "R9", "ready before request", 32'(reqReady), 1);
    reqValid = 1'b1; reqSel = sel; reqOff = off; clrRd = 1'b1;
    @(negedge clk);
    clrRd = 1'b0;
    if (holdJunk) begin reqSel = 16'h0000; reqOff = 32'hDEAD0000; end
    else reqValid = 1'b0;
    lat = 1;
    chk(busy, "R9", "busy after accept", 32'(busy), 1);
    while (!resValid && lat < 20) begin
      chk(!reqReady, "R9", "ready while busy", 32'(reqReady), 0);
      @(negedge clk);
      lat++;
    end
    reqValid = 1'b0;
    chk(lat == expLat, "R8", {req, " latency"}, 32'(lat), 32'(expLat));
    chk(resFault == expFault, req, "fault flag", 32'(resFault), 32'(expFault));
    chk(resLinAddr == expLin, req, "linear address", resLinAddr, expLin);
    chk(rdCount == (expFault ? 0 : 2), expFault ? "R6" : "R3", "read count",
        32'(rdCount), expFault ? 0 : 2);
    if (!expFault) begin
      chk(rdAddr0 == firstAddr, "R3", "low word addr", rdAddr0, firstAddr);
      chk(rdAddr1 == firstAddr + 4, "R3", "high word addr", rdAddr1, firstAddr + 4);
    end
    @(negedge clk);
    chk(!resValid, "R8", "pulse one cycle", 32'(resValid), 0);
    chk(reqReady && !busy, "R9", "idle after result", 32'(reqReady), 1);
  endtask

  task automatic t_reset;
    chk(reqReady, "R10", "reqReady", 32'(reqReady), 1);
    chk(!busy, "R10", "busy", 32'(busy), 0);
    chk(!memReqValid, "R10", "memReqValid", 32'(memReqValid), 0);
    chk(!resValid, "R10", "resValid", 32'(resValid), 0);
  endtask

  task automatic t_zero_base;  // R11
    mem[(32'h160) >> 2]       = 32'h0000ffff;
    mem[((32'h160) >> 2) + 1] = 32'h00cf9a00;
    xlate("R11", 16'h0060, 32'h0804_8000, 32'h0804_8000, 1'b0, 32'h160, 1'b0);
  endtask

  task automatic t_scatter;  // R4, R5
    xlate("R4", 16'h0018, 32'h10, 32'h1234_5688, 1'b0, 32'h118, 1'b0);
    xlate("R5", 16'h0020, 32'h2000_0000, 32'h1000_0000, 1'b0, 32'h120, 1'b0);
  endtask

  task automatic t_tables;  // R2, R7
    xlate("R2", 16'h001C, 32'h1, 32'h00AB_CDF0, 1'b0, 32'h218, 1'b0);
    xlate("R7", 16'h0004, 32'h5, 32'h0000_0405, 1'b0, 32'h200, 1'b0);
  endtask

  task automatic t_rpl;  // R1
    xlate("R1", 16'h001B, 32'h10, 32'h1234_5688, 1'b0, 32'h118, 1'b0);
    xlate("R1", 16'h0001, 32'h10, 32'h0, 1'b1, 32'h0, 1'b0);
  endtask

  task automatic t_limits;  // R6
    xlate("R6", 16'h00F8, 32'h0, 32'h0000_1000, 1'b0, 32'h1F8, 1'b0);
    xlate("R6", 16'h0100, 32'h0, 32'h0, 1'b1, 32'h0, 1'b0);
    xlate("R6", 16'h003C, 32'h77, 32'h77, 1'b0, 32'h238, 1'b0);
    xlate("R6", 16'h0044, 32'h77, 32'h0, 1'b1, 32'h0, 1'b0);
  endtask

  task automatic t_null;  // R7
    xlate("R7", 16'h0000, 32'h99, 32'h0, 1'b1, 32'h0, 1'b0);
    xlate("R7", 16'h0003, 32'h99, 32'h0, 1'b1, 32'h0, 1'b0);
  endtask

  task automatic t_held;  // R9
    xlate("R9", 16'h0018, 32'h10, 32'h1234_5688, 1'b0, 32'h118, 1'b1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    putDesc(32'h118, 32'h1234_5678);
    putDesc(32'h120, 32'hF000_0000);
    putDesc(32'h1F8, 32'h0000_1000);
    putDesc(32'h218, 32'h00AB_CDEF);
    putDesc(32'h200, 32'h0000_0400);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_base();
    t_scatter();
    t_tables();
    t_rpl();
    t_limits();
    t_null();
    t_held();
    doneFlag = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!doneFlag && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    if (!doneFlag) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule